// File: doc/BRIEF.md
# Coalescing Miss Queue with Shifting Stages

This block holds the outstanding misses of one cache bank. Each miss names a whole cache block. The first miss to a block takes a new entry at the back of the queue. A later miss to the same block is folded into that entry and does not take a second one. A store that is folded in sets the bit for its word in the entry's write mask and places its data in that word's lane. A load that is folded in waits on the fill that is already pending.

The queue has no read or write pointers. It is a chain of register stages. An entry enters at the tail stage and moves forward one stage per clock whenever the stage in front of it is empty or is emptying on the same clock. The front stage is offered to the bank. The bank takes it by raising `deq_ready`.

The word widths, block address width and UUID width come from the package. The number of stages is the top-level parameter `DEPTH`.

Top module: `mshr_coalesce_q`

## Requirements
- R1: After synchronous reset, every stage is empty, `deq_valid` is 0, and `enq_ready` is 1 for any miss.
- R2: An accepted miss whose block address matches no valid entry allocates a new entry. The entry stores the address and the miss's UUID. A load allocates with write mask 0. A store allocates with only mask bit `enq_word` set, and its data goes in lane `enq_word`, which is bits `[enq_word*WORD_W +: WORD_W]` of `deq_data`. All other lanes are 0.
- R3: An accepted store whose block matches a valid entry allocates nothing new. It sets mask bit `enq_word` of that entry and writes lane `enq_word`. When two stores hit the same word, the later store's data replaces the earlier one.
- R4: A load that matches a valid entry is accepted only if its UUID equals that entry's UUID, and it then changes nothing. A load with a different UUID sees `enq_ready` = 0.
- R5: A matching store is accepted whatever its UUID, and the entry keeps the UUID it was allocated with.
- R6: Entries reach the front in the order they were allocated. Each entry advances one stage per clock when the stage ahead is free or is emptying. In an empty queue, a new entry shows at the front (`deq_valid` = 1) after `DEPTH`-1 further clock edges following the edge that accepts it.
- R7: While `deq_valid` = 1 and `deq_ready` = 0, the front entry keeps its address and UUID. On an edge with both high, that entry leaves the queue.
- R8: When all `DEPTH` stages are valid and no entry matches the miss, `enq_ready` = 0. A store that matches an entry is still accepted when the queue is full.
- R9: A miss that matches the front entry on the same edge that the bank takes that entry allocates a fresh entry at the tail instead of merging. No block ever occupies two valid stages.
- R10: When `enq_valid` = 0, the queue contents do not change apart from shifting and dequeue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | A miss is offered |
| enq_ready | output | 1 | The offered miss can be taken this cycle |
| enq_addr | input | BLK_AW | Block address of the miss |
| enq_is_store | input | 1 | 1 for a store miss, 0 for a load miss |
| enq_word | input | OFF_W | Word offset inside the block |
| enq_data | input | WORD_W | Store data |
| enq_uuid | input | UUID_W | Tag of the issuing instruction |
| deq_valid | output | 1 | The front stage holds an entry |
| deq_ready | input | 1 | The bank takes the front entry |
| deq_addr | output | BLK_AW | Block address of the front entry |
| deq_mask | output | WORDS | Per-word write mask of the front entry |
| deq_data | output | WORDS*WORD_W | Buffered store words of the front entry |
| deq_uuid | output | UUID_W | UUID of the front entry |

## Verification
The bench targets three corner cases:
- Repeated stores to one word. A design that ORs the data instead of replacing it shows a corrupted lane.
- A load whose UUID conflicts with the entry's. A design that accepts it drops one UUID.
- A miss that hits the front entry on the edge the bank takes that entry. A design that still merges loses the store data.

Further runs fill the queue so that ready must fall for fresh blocks but stay high for matching stores. They also check the exact cycle at which a lone entry reaches the front, because an off-by-one in the shift chain moves it. A long mixed run over a few reused block addresses, with random bank backpressure, stresses shifting over bubbles while merges land on moving entries.

// File: rtl/mshrq_pkg.sv
package mshrq_pkg;
    parameter int BLK_AW = 12;
    parameter int WORDS  = 4;
    parameter int WORD_W = 16;
    parameter int UUID_W = 6;
    localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LINE_W = WORDS * WORD_W;

    typedef logic [WORDS-1:0][WORD_W-1:0] line_t;

    typedef struct packed {
        logic              valid;
        logic [BLK_AW-1:0] addr;
        logic [WORDS-1:0]  mask;
        line_t             data;
        logic [UUID_W-1:0] uuid;
    } mshr_ent_t;

    function automatic mshr_ent_t put_word(mshr_ent_t e, logic [OFF_W-1:0] w,
                                           logic [WORD_W-1:0] d);
        mshr_ent_t r;
        r = e;
        r.mask[w] = 1'b1;
        r.data[w] = d;
        return r;
    endfunction
endpackage

// File: rtl/mshrq_match.sv
module mshrq_match
    import mshrq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  mshr_ent_t [DEPTH-1:0] ent,
    input  logic [BLK_AW-1:0]     req_addr,
    output logic [DEPTH-1:0]      hit_vec,
    output logic [UUID_W-1:0]     hit_uuid
);
    always_comb begin
        hit_uuid = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hit_vec[i] = ent[i].valid && (ent[i].addr == req_addr);
            if (hit_vec[i]) hit_uuid = hit_uuid | ent[i].uuid;
        end
    end
endmodule

// File: rtl/mshrq_stage.sv
module mshrq_stage
    import mshrq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  mshr_ent_t in_ent,
    input  logic      drop,
    input  mshr_ent_t keep_ent,
    output mshr_ent_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (take) q <= in_ent;
        else if (drop) q <= '0;
        else           q <= keep_ent;
    end
endmodule

// File: rtl/mshr_coalesce_q.sv
module mshr_coalesce_q
    import mshrq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [BLK_AW-1:0] enq_addr,
    input  logic              enq_is_store,
    input  logic [OFF_W-1:0]  enq_word,
    input  logic [WORD_W-1:0] enq_data,
    input  logic [UUID_W-1:0] enq_uuid,
    output logic              deq_valid,
    input  logic              deq_ready,
    output logic [BLK_AW-1:0] deq_addr,
    output logic [WORDS-1:0]  deq_mask,
    output logic [LINE_W-1:0] deq_data,
    output logic [UUID_W-1:0] deq_uuid
);
    localparam int TAIL = DEPTH - 1;

    mshr_ent_t [DEPTH-1:0] ent_q;
    mshr_ent_t [DEPTH-1:0] ent_upd;
    mshr_ent_t             new_ent;
    logic [DEPTH-1:0]      st_valid;
    logic [DEPTH-1:0]      hit_vec;
    logic [DEPTH-1:0]      mv;
    logic [UUID_W-1:0]     hit_uuid;
    logic                  hit, head_go, hit_live, all_full;
    logic                  fire, merge_en, alloc_en;

    mshrq_match #(.DEPTH(DEPTH)) u_match (
        .ent      (ent_q),
        .req_addr (enq_addr),
        .hit_vec  (hit_vec),
        .hit_uuid (hit_uuid)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) st_valid[i] = ent_q[i].valid;
    end

    assign all_full = &st_valid;
    assign hit      = |hit_vec;
    assign head_go  = ent_q[0].valid && deq_ready;
    // a match on the departing front entry cannot absorb the miss
    assign hit_live = hit && !(hit_vec[0] && head_go);

    assign enq_ready = hit ? (enq_is_store || (hit_uuid == enq_uuid)) : !all_full;
    assign fire      = enq_valid && enq_ready;
    assign merge_en  = fire && hit_live && enq_is_store;
    assign alloc_en  = fire && !hit_live;

    // advance chain: a stage moves when the one ahead is empty or moving
    always_comb begin
        logic carry;
        carry = head_go;
        mv[0] = carry;
        for (int i = 1; i < DEPTH; i++) begin
            carry = st_valid[i] && (!st_valid[i-1] || carry);
            mv[i] = carry;
        end
    end

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.addr  = enq_addr;
        new_ent.uuid  = enq_uuid;
        if (enq_is_store) new_ent = put_word(new_ent, enq_word, enq_data);
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (merge_en && hit_vec[i]) ent_upd[i] = put_word(ent_q[i], enq_word, enq_data);
            else                        ent_upd[i] = ent_q[i];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic      take_g;
        mshr_ent_t in_g;
        if (g == TAIL) begin : g_tail
            assign take_g = alloc_en;
            assign in_g   = new_ent;
        end else begin : g_body
            assign take_g = mv[g+1];
            assign in_g   = ent_upd[g+1];
        end
        mshrq_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .take     (take_g),
            .in_ent   (in_g),
            .drop     (mv[g]),
            .keep_ent (ent_upd[g]),
            .q        (ent_q[g])
        );
    end

    assign deq_valid = ent_q[0].valid;
    assign deq_addr  = ent_q[0].addr;
    assign deq_mask  = ent_q[0].mask;
    assign deq_data  = ent_q[0].data;
    assign deq_uuid  = ent_q[0].uuid;
endmodule

// File: rtl/mshrq_checker.sv
module mshrq_checker
    import mshrq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  enq_valid,
    input logic                  enq_ready,
    input logic [BLK_AW-1:0]     enq_addr,
    input logic                  deq_valid,
    input logic                  deq_ready,
    input logic [BLK_AW-1:0]     deq_addr,
    input logic [UUID_W-1:0]     deq_uuid,
    input mshr_ent_t [DEPTH-1:0] ent
);
    logic dup, any_match, full;
    int   occ;

    always_comb begin
        dup = 1'b0;
        any_match = 1'b0;
        full = 1'b1;
        occ = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent[i].valid) occ = occ + 1;
            else full = 1'b0;
            if (ent[i].valid && ent[i].addr == enq_addr) any_match = 1'b1;
            for (int j = i + 1; j < DEPTH; j++)
                if (ent[i].valid && ent[j].valid && ent[i].addr == ent[j].addr) dup = 1'b1;
        end
    end

    a_r1_empty_after_reset: assert property (@(posedge clk) rst |=> !deq_valid);
    a_r9_block_unique: assert property (@(posedge clk) disable iff (rst) !dup);
    a_r8_full_refuse: assert property (@(posedge clk) disable iff (rst)
        (full && enq_valid && enq_ready) |-> any_match);
    a_r7_head_hold: assert property (@(posedge clk) disable iff (rst)
        (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_addr) && $stable(deq_uuid)));
    a_r6_one_alloc_per_cycle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (occ <= $past(occ) + 1));
endmodule

bind mshr_coalesce_q mshrq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .enq_addr  (enq_addr),
    .deq_valid (deq_valid),
    .deq_ready (deq_ready),
    .deq_addr  (deq_addr),
    .deq_uuid  (deq_uuid),
    .ent       (ent_q)
);

// File: tb/mshr_coalesce_q_tb_top.sv
module mshr_coalesce_q_tb_top;
    import mshrq_pkg::*;
    localparam int D = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enq_valid = 1'b0, enq_is_store = 1'b0, deq_ready = 1'b0;
    logic [BLK_AW-1:0] enq_addr = '0;
    logic [OFF_W-1:0]  enq_word = '0;
    logic [WORD_W-1:0] enq_data = '0;
    logic [UUID_W-1:0] enq_uuid = '0;
    logic              enq_ready, deq_valid;
    logic [BLK_AW-1:0] deq_addr;
    logic [WORDS-1:0]  deq_mask;
    logic [LINE_W-1:0] deq_data;
    logic [UUID_W-1:0] deq_uuid;

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural model: ordered list of entries with stage positions
    int                n = 0;
    logic [BLK_AW-1:0] ma [D];
    logic [WORDS-1:0]  mm [D];
    logic [LINE_W-1:0] md [D];
    logic [UUID_W-1:0] mu [D];
    int                mp [D];

    always #5 clk = ~clk;

    mshr_coalesce_q #(.DEPTH(D)) dut_i (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
        .enq_is_store(enq_is_store), .enq_word(enq_word), .enq_data(enq_data),
        .enq_uuid(enq_uuid), .deq_valid(deq_valid), .deq_ready(deq_ready),
        .deq_addr(deq_addr), .deq_mask(deq_mask), .deq_data(deq_data),
        .deq_uuid(deq_uuid)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare, advance model at posedge
    task automatic step(input bit ev, input bit st, input logic [BLK_AW-1:0] a,
                        input int w, input logic [WORD_W-1:0] d,
                        input logic [UUID_W-1:0] u, input bit dr,
                        input int exp_rdy = -1, input string tag = "");
        int  hit;
        bit  er, leave, fire, live;
        int  prev;
        enq_valid = ev; enq_is_store = st; enq_addr = a; enq_word = OFF_W'(w);
        enq_data = d; enq_uuid = u; deq_ready = dr;
        #1;
        hit = -1;
        for (int k = 0; k < n; k++) if (ma[k] == a) hit = k;
        er = (hit >= 0) ? (st || mu[hit] == u) : (n < D);
        chk(enq_ready == er, (hit >= 0) ? "R4 enq_ready" : "R8 enq_ready", 64'(enq_ready), 64'(er));
        if (exp_rdy >= 0) chk(enq_ready == exp_rdy[0], tag, 64'(enq_ready), 64'(exp_rdy));
        chk(deq_valid == (n > 0 && mp[0] == 0), "R6 deq_valid", 64'(deq_valid),
            64'(n > 0 && mp[0] == 0));
        if (n > 0 && mp[0] == 0) begin
            chk(deq_addr == ma[0], "R7 deq_addr", 64'(deq_addr), 64'(ma[0]));
            chk(deq_mask == mm[0], "R3 deq_mask", 64'(deq_mask), 64'(mm[0]));
            chk(deq_data == md[0], "R3 deq_data", 64'(deq_data), 64'(md[0]));
            chk(deq_uuid == mu[0], "R5 deq_uuid", 64'(deq_uuid), 64'(mu[0]));
        end
        leave = (n > 0 && mp[0] == 0 && dr);
        fire  = ev && er;
        live  = (hit >= 0) && !(hit == 0 && leave);
        @(posedge clk);
        if (fire && live && st) begin
            mm[hit][w] = 1'b1;
            md[hit][w*WORD_W +: WORD_W] = d;
        end
        if (leave) begin
            for (int k = 1; k < n; k++) begin
                ma[k-1] = ma[k]; mm[k-1] = mm[k]; md[k-1] = md[k];
                mu[k-1] = mu[k]; mp[k-1] = mp[k];
            end
            n--;
        end
        prev = -1;
        for (int k = 0; k < n; k++) begin
            mp[k] = (mp[k] - 1 > prev + 1) ? mp[k] - 1 : prev + 1;
            prev = mp[k];
        end
        if (fire && !live) begin
            ma[n] = a; mu[n] = u; mp[n] = D - 1;
            mm[n] = st ? (WORDS'(1) << w) : '0;
            md[n] = st ? (LINE_W'(d) << (w * WORD_W)) : '0;
            n++;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int c, input bit dr);
        for (int i = 0; i < c; i++) step(0, 0, '0, 0, '0, '0, dr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(deq_valid == 1'b0, "R1 deq_valid", 64'(deq_valid), 0);
        chk(enq_ready == 1'b1, "R1 enq_ready", 64'(enq_ready), 1);

        // R2 / R6: lone load reaches the front after D-1 more edges
        step(1, 0, 12'h011, 0, '0, 6'd1, 0, 1, "R2 alloc");
        idle(D - 2, 0);
        chk(deq_valid == 1'b0, "R6 early", 64'(deq_valid), 0);
        idle(1, 0);
        chk(deq_valid == 1'b1, "R6 arrival", 64'(deq_valid), 1);
        chk(deq_mask == '0, "R2 load mask", 64'(deq_mask), 0);

        // R3 / R5: store merges, later store to same word wins
        step(1, 1, 12'h011, 1, 16'hAAAA, 6'd9, 0, 1, "R5 store any uuid");
        step(1, 1, 12'h011, 1, 16'hBBBB, 6'd9, 0);
        step(1, 1, 12'h011, 3, 16'h1111, 6'd9, 0);
        chk(deq_mask == 4'b1010, "R3 mask", 64'(deq_mask), 64'hA);
        chk(deq_data[WORD_W +: WORD_W] == 16'hBBBB, "R3 overwrite",
            64'(deq_data[WORD_W +: WORD_W]), 64'hBBBB);
        chk(deq_uuid == 6'd1, "R5 uuid kept", 64'(deq_uuid), 1);

        // R4: load sharing the fill
        step(1, 0, 12'h011, 0, '0, 6'd7, 0, 0, "R4 uuid clash");
        step(1, 0, 12'h011, 0, '0, 6'd1, 0, 1, "R4 same uuid");

        // R10: an unoffered store leaves the entry alone
        step(0, 1, 12'h011, 0, 16'hFFFF, 6'd1, 0);
        chk(deq_mask == 4'b1010, "R10 ignored", 64'(deq_mask), 64'hA);

        // R8: fill every stage
        step(1, 0, 12'h022, 0, '0, 6'd2, 0);
        step(1, 0, 12'h033, 0, '0, 6'd3, 0);
        step(1, 0, 12'h044, 0, '0, 6'd4, 0);
        step(1, 0, 12'h055, 0, '0, 6'd5, 0, 0, "R8 full fresh block");
        step(1, 1, 12'h033, 0, 16'h7777, 6'd6, 0, 1, "R8 full merge");

        // R7: hold, then release
        idle(1, 0);
        chk(deq_addr == 12'h011, "R7 held", 64'(deq_addr), 64'h011);
        idle(1, 1);
        chk(deq_addr == 12'h022, "R7 next", 64'(deq_addr), 64'h022);
        idle(6, 1);
        chk(deq_valid == 1'b0, "R6 drained", 64'(deq_valid), 0);

        // R9: miss on the departing front entry allocates afresh
        step(1, 0, 12'h066, 0, '0, 6'd1, 0);
        idle(D - 1, 0);
        step(1, 1, 12'h066, 2, 16'h1234, 6'd2, 1, 1, "R9 accept");
        chk(deq_valid == 1'b0, "R9 front gone", 64'(deq_valid), 0);
        idle(D - 1, 0);
        chk(deq_valid == 1'b1, "R9 fresh entry", 64'(deq_valid), 1);
        chk(deq_mask == 4'b0100, "R9 mask", 64'(deq_mask), 64'h4);
        chk(deq_uuid == 6'd2, "R9 uuid", 64'(deq_uuid), 2);
        idle(D + 2, 1);

        // mixed traffic over a few reused blocks
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) < 7, $urandom % 2, 12'(12'h100 + ($urandom % 6)),
                 int'($urandom % WORDS), 16'($urandom), 6'($urandom % 4),
                 ($urandom % 10) < 4);
        end
        idle(2 * D + 2, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule